// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns processor-side addresses into PCI bus addresses. It holds a set of programmable outbound windows. In the default build there are three windows, and two of them carry a full remap. Each remapping window has a 64-bit local base, a 64-bit PCI base and a 32-bit size/enable word. The last window keeps only a size word: it stores that word and returns it on read, but it never translates anything.

Software programs the windows through a 32-bit register port. Writes are synchronous and reads are combinational. Each 64-bit base is split into two separately written 32-bit halves.

The lookup side is purely combinational. It takes a local address and checks it against every window at once. It returns a hit flag, the index of the winning window and the translated address, which is the PCI base plus the offset of the address into the window. Generating the bus transactions themselves happens outside this block.

Top module: `outbound_xlate`

## Requirements
- R1: After reset every window register reads as zero and no lookup address produces a hit.
- R2: Register offsets are as follows. Remapping window k (k = 0, 1) starts at 0x68 + 0x14·k and has, at +0x0/+0x4/+0x8/+0xC/+0x10, the local base bits 31:0, the local base bits 63:32, the size word, the PCI base bits 31:0 and the PCI base bits 63:32. The size-only window's size word is at 0x90. Every register reads back exactly what was last written to it.
- R3: Writing one 32-bit half of a 64-bit base leaves the other half unchanged.
- R4: A window whose size word has bit 0 clear never hits.
- R5: The window size is (~(size_word & 0xFFFFFFFE)) + 1 in 32 bits. An address hits when local_base <= addr < local_base + size, with both bounds exact.
- R6: If that size computation yields zero (size word 0x00000001), the size is 0xFFFFFFFF.
- R7: On a hit the output address is pci_base + (addr − local_base) in 64 bits. This holds even for a window that ends exactly at the top of the 64-bit space.
- R8: When several enabled windows hit, the lowest-numbered one is reported.
- R9: On a miss, the hit flag is 0, the index is 0 and the output address is 0.
- R10: The size-only window (index 2) stores its size word and returns it on read, but never produces a hit, even with bit 0 set.
- R11: Reads of unmapped or unaligned offsets return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| lk_addr | input | 64 | Local address to translate |
| lk_hit | output | 1 | A window matched |
| lk_idx | output | 2 | Index of the matching window |
| lk_pci_addr | output | 64 | Translated PCI address, zero on miss |

## Verification
Lookups are probed at a window's first byte, at its last byte, one byte past its end and one byte below its base. This separates a correct exclusive upper bound from an off-by-one in either direction. A window with size word 0x1 and one that ends at the top of the address space test the zero-size substitution and the 64-bit offset arithmetic. Two overlapping windows, with the lower one then disabled and then shrunk, show whether the priority order is right or whether a disabled window still claims addresses. Distinct values in every register, followed by partial rewrites, show whether the offsets decode correctly and whether a half-write disturbs its partner half.

// File: rtl/owt_pkg.sv
`timescale 1ns/1ps
package owt_pkg;
   // width of one register half and of the size word
   localparam int OWT_HALF_W = 32;

   // field order inside a remapping window's register group
   typedef enum logic [2:0] {
      FLD_LOC_LO = 3'd0,
      FLD_LOC_HI = 3'd1,
      FLD_SIZE   = 3'd2,
      FLD_PCI_LO = 3'd3,
      FLD_PCI_HI = 3'd4
   } owt_fld_e;

   localparam int OWT_FLDS = 5;

   // decode a size word into a window length; zero becomes all ones
   function automatic logic [OWT_HALF_W-1:0] owt_size(input logic [OWT_HALF_W-1:0] sw);
      logic [OWT_HALF_W-1:0] masked;
      logic [OWT_HALF_W-1:0] len;
      masked = sw & ~OWT_HALF_W'(1);
      len    = ~masked + OWT_HALF_W'(1);
      if (len == '0) len = '1;
      return len;
   endfunction
endpackage

// File: rtl/owt_regfile.sv
`timescale 1ns/1ps
module owt_regfile
   import owt_pkg::*;
#(
   parameter int NUM_WIN   = 3,
   parameter int NUM_REMAP = 2,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 64,
   parameter int AW        = 8,
   parameter int BASE_OFS  = 'h68
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 reg_wr,
   input  logic [AW-1:0]                        reg_addr,
   input  logic [DATA_W-1:0]                    reg_wdata,
   output logic [DATA_W-1:0]                    reg_rdata,
   output logic [NUM_REMAP-1:0][ADDR_W-1:0]     loc_base,
   output logic [NUM_REMAP-1:0][ADDR_W-1:0]     pci_base,
   output logic [NUM_REMAP-1:0][DATA_W-1:0]     size_word
);
   localparam int GRP_BYTES = OWT_FLDS * 4;
   localparam int TAIL_OFS  = BASE_OFS + GRP_BYTES * NUM_REMAP;

   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("owt_regfile: ADDR_W must be twice DATA_W");
   end
   if (TAIL_OFS + 4 * (NUM_WIN - NUM_REMAP) > (1 << AW)) begin : g_bad_map
      $error("owt_regfile: register map does not fit in AW bits");
   end

   function automatic logic [AW-1:0] reg_ofs(input int win, input int fld);
      if (win < NUM_REMAP) return AW'(BASE_OFS + GRP_BYTES * win + 4 * fld);
      return AW'(TAIL_OFS + 4 * (win - NUM_REMAP));
   endfunction

   logic [NUM_WIN-1:0][DATA_W-1:0] sz_q;

   // size words for all windows, remap or not
   for (genvar k = 0; k < NUM_WIN; k++) begin : g_size
      always_ff @(posedge clk) begin
         if (rst)
            sz_q[k] <= '0;
         else if (reg_wr && reg_addr == reg_ofs(k, int'(FLD_SIZE)))
            sz_q[k] <= reg_wdata;
      end
   end

   // base registers, remapping windows only
   for (genvar k = 0; k < NUM_REMAP; k++) begin : g_base
      logic wr_ll, wr_lh, wr_pl, wr_ph;
      assign wr_ll = reg_wr && reg_addr == reg_ofs(k, int'(FLD_LOC_LO));
      assign wr_lh = reg_wr && reg_addr == reg_ofs(k, int'(FLD_LOC_HI));
      assign wr_pl = reg_wr && reg_addr == reg_ofs(k, int'(FLD_PCI_LO));
      assign wr_ph = reg_wr && reg_addr == reg_ofs(k, int'(FLD_PCI_HI));

      always_ff @(posedge clk) begin
         if (rst) begin
            loc_base[k] <= '0;
            pci_base[k] <= '0;
         end else begin
            if (wr_ll) loc_base[k][DATA_W-1:0]      <= reg_wdata;
            if (wr_lh) loc_base[k][ADDR_W-1:DATA_W] <= reg_wdata;
            if (wr_pl) pci_base[k][DATA_W-1:0]      <= reg_wdata;
            if (wr_ph) pci_base[k][ADDR_W-1:DATA_W] <= reg_wdata;
         end
      end

      assign size_word[k] = sz_q[k];

      AST_LOC_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
         wr_ll |=> $stable(loc_base[k][ADDR_W-1:DATA_W])); // R3
      AST_LOC_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
         wr_lh |=> $stable(loc_base[k][DATA_W-1:0])); // R3
      AST_PCI_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
         wr_pl |=> $stable(pci_base[k][ADDR_W-1:DATA_W])); // R3
      AST_PCI_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
         wr_ph |=> $stable(pci_base[k][DATA_W-1:0])); // R3
   end

   // read mux; unmatched offsets fall through to zero
   always_comb begin
      reg_rdata = '0;
      for (int k = 0; k < NUM_WIN; k++) begin
         if (reg_addr == reg_ofs(k, int'(FLD_SIZE))) reg_rdata = sz_q[k];
      end
      for (int k = 0; k < NUM_REMAP; k++) begin
         if (reg_addr == reg_ofs(k, int'(FLD_LOC_LO))) reg_rdata = loc_base[k][DATA_W-1:0];
         if (reg_addr == reg_ofs(k, int'(FLD_LOC_HI))) reg_rdata = loc_base[k][ADDR_W-1:DATA_W];
         if (reg_addr == reg_ofs(k, int'(FLD_PCI_LO))) reg_rdata = pci_base[k][DATA_W-1:0];
         if (reg_addr == reg_ofs(k, int'(FLD_PCI_HI))) reg_rdata = pci_base[k][ADDR_W-1:DATA_W];
      end
   end

   AST_UNMAPPED_WR_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr[1:0] != 2'b00) |=> $stable(sz_q)); // R11
endmodule

// File: rtl/owt_window.sv
`timescale 1ns/1ps
module owt_window
   import owt_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int SZ_W   = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic [ADDR_W-1:0] loc_base,
   input  logic [ADDR_W-1:0] pci_base,
   input  logic [SZ_W-1:0]   size_word,
   output logic              hit,
   output logic [ADDR_W-1:0] xl_addr
);
   if (SZ_W != OWT_HALF_W) begin : g_bad_sz
      $error("owt_window: SZ_W must match the package half width");
   end
   if (ADDR_W < SZ_W) begin : g_bad_aw
      $error("owt_window: ADDR_W must be at least SZ_W");
   end

   logic [SZ_W-1:0]   win_len;
   logic [ADDR_W-1:0] offset;
   logic              above_base;
   logic              inside_len;

   // subtract-then-compare avoids overflow of base + length
   assign win_len    = owt_size(size_word);
   assign offset     = lk_addr - loc_base;
   assign above_base = lk_addr >= loc_base;
   assign inside_len = offset < {{(ADDR_W-SZ_W){1'b0}}, win_len};
   assign hit        = size_word[0] && above_base && inside_len;
   assign xl_addr    = pci_base + offset;

   AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (rst)
      !size_word[0] |-> !hit); // R4
   AST_HIT_NOT_BELOW_BASE: assert property (@(posedge clk) disable iff (rst)
      hit |-> (lk_addr >= loc_base)); // R5
   AST_NONZERO_LEN: assert property (@(posedge clk) disable iff (rst)
      win_len != '0); // R6
endmodule

// File: rtl/owt_prio.sv
`timescale 1ns/1ps
module owt_prio #(
   parameter int NUM_REMAP = 2,
   parameter int ADDR_W    = 64,
   parameter int IDX_W     = 2
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NUM_REMAP-1:0]             win_hit,
   input  logic [NUM_REMAP-1:0][ADDR_W-1:0] win_xl,
   output logic                             hit,
   output logic [IDX_W-1:0]                 idx,
   output logic [ADDR_W-1:0]                addr
);
   if ((1 << IDX_W) < NUM_REMAP) begin : g_bad_idx
      $error("owt_prio: IDX_W too narrow");
   end

   // scan high to low so the lowest hitting index is left standing
   always_comb begin
      hit  = 1'b0;
      idx  = '0;
      addr = '0;
      for (int k = NUM_REMAP - 1; k >= 0; k--) begin
         if (win_hit[k]) begin
            hit  = 1'b1;
            idx  = IDX_W'(k);
            addr = win_xl[k];
         end
      end
   end

   logic [NUM_REMAP-1:0] lower_mask;
   always_comb begin
      lower_mask = '0;
      for (int k = 0; k < NUM_REMAP; k++) lower_mask[k] = (k < int'(idx));
   end

   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
      hit |-> ((win_hit & lower_mask) == '0)); // R8
   AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
      !hit |-> (addr == '0 && idx == '0)); // R9
   AST_HIT_MATCHES_VECTOR: assert property (@(posedge clk) disable iff (rst)
      hit == (win_hit != '0)); // R9
endmodule

// File: rtl/outbound_xlate.sv
`timescale 1ns/1ps
module outbound_xlate
   import owt_pkg::*;
#(
   parameter int NUM_WIN   = 3,
   parameter int NUM_REMAP = 2,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 64,
   parameter int REG_AW    = 8,
   parameter int BASE_OFS  = 'h68
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         reg_wr,
   input  logic [REG_AW-1:0]            reg_addr,
   input  logic [DATA_W-1:0]            reg_wdata,
   output logic [DATA_W-1:0]            reg_rdata,
   input  logic [ADDR_W-1:0]            lk_addr,
   output logic                         lk_hit,
   output logic [$clog2(NUM_WIN)-1:0]   lk_idx,
   output logic [ADDR_W-1:0]            lk_pci_addr
);
   localparam int IDX_W = $clog2(NUM_WIN);

   if (NUM_REMAP < 1 || NUM_REMAP > NUM_WIN) begin : g_bad_cnt
      $error("outbound_xlate: NUM_REMAP must be in 1..NUM_WIN");
   end
   if (NUM_WIN < 2) begin : g_bad_win
      $error("outbound_xlate: NUM_WIN must be at least 2");
   end

   logic [NUM_REMAP-1:0][ADDR_W-1:0] loc_base;
   logic [NUM_REMAP-1:0][ADDR_W-1:0] pci_base;
   logic [NUM_REMAP-1:0][DATA_W-1:0] size_word;
   logic [NUM_REMAP-1:0]             win_hit;
   logic [NUM_REMAP-1:0][ADDR_W-1:0] win_xl;

   owt_regfile #(
      .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .DATA_W(DATA_W),
      .ADDR_W(ADDR_W), .AW(REG_AW), .BASE_OFS(BASE_OFS)
   ) i_regs (
      .clk(clk), .rst(rst),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .loc_base(loc_base), .pci_base(pci_base), .size_word(size_word)
   );

   // only windows with a remap get a comparator
   for (genvar k = 0; k < NUM_REMAP; k++) begin : g_win
      owt_window #(.ADDR_W(ADDR_W), .SZ_W(DATA_W)) i_win (
         .clk(clk), .rst(rst),
         .lk_addr(lk_addr),
         .loc_base(loc_base[k]), .pci_base(pci_base[k]),
         .size_word(size_word[k]),
         .hit(win_hit[k]), .xl_addr(win_xl[k])
      );
   end

   owt_prio #(.NUM_REMAP(NUM_REMAP), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_prio (
      .clk(clk), .rst(rst),
      .win_hit(win_hit), .win_xl(win_xl),
      .hit(lk_hit), .idx(lk_idx), .addr(lk_pci_addr)
   );

   AST_SIZE_ONLY_NEVER_WINS: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> (int'(lk_idx) < NUM_REMAP)); // R10
   AST_RESET_NO_HIT: assert property (@(posedge clk)
      $past(rst) |-> !lk_hit); // R1
endmodule

// File: tb/test_outbound_xlate.sv
`timescale 1ns/1ps
module test_outbound_xlate;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] lk_addr = '0;
   logic        lk_hit;
   logic [1:0]  lk_idx;
   logic [63:0] lk_pci_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   outbound_xlate i_outbound_xlate (
      .clk(clk), .rst(rst),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_pci_addr(lk_pci_addr)
   );

   // offsets per the register map requirement (R2)
   function automatic logic [7:0] ofs(input int win, input int fld);
      if (win < 2) return 8'(8'h68 + 8'h14 * win + 4 * fld);
      return 8'h90;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         errors++;
         $display("FAIL %s read 0x%02h: actual=0x%08h expected=0x%08h", req, a, reg_rdata, exp);
      end
   endtask

   task automatic chk_lk(input string req, input logic [63:0] a, input logic eh,
                         input logic [1:0] ei, input logic [63:0] ea);
      lk_addr = a;
      #1;
      checks++;
      if (lk_hit !== eh || lk_idx !== ei || lk_pci_addr !== ea) begin
         errors++;
         $display("FAIL %s lookup 0x%016h: actual hit=%0b idx=%0d addr=0x%016h expected hit=%0b idx=%0d addr=0x%016h",
                  req, a, lk_hit, lk_idx, lk_pci_addr, eh, ei, ea);
      end
   endtask

   task automatic prog(input int k, input logic [63:0] lb, input logic [63:0] pb, input logic [31:0] sw);
      wr(ofs(k, 0), lb[31:0]);
      wr(ofs(k, 1), lb[63:32]);
      wr(ofs(k, 3), pb[31:0]);
      wr(ofs(k, 4), pb[63:32]);
      wr(ofs(k, 2), sw);
   endtask

   task automatic t_reset;
      for (int k = 0; k < 2; k++)
         for (int f = 0; f < 5; f++) chk_rd("R1", ofs(k, f), 32'h0);
      chk_rd("R1", 8'h90, 32'h0);
      chk_lk("R1", 64'h0, 1'b0, 2'd0, 64'h0);
      chk_lk("R1", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, 64'h0);
   endtask

   task automatic t_regmap;
      for (int k = 0; k < 2; k++)
         for (int f = 0; f < 5; f++) wr(ofs(k, f), 32'hA500_0000 | (k << 8) | f);
      wr(8'h90, 32'hB000_0002);
      for (int k = 0; k < 2; k++)
         for (int f = 0; f < 5; f++) chk_rd("R2", ofs(k, f), 32'hA500_0000 | (k << 8) | f);
      chk_rd("R2", 8'h90, 32'hB000_0002);
   endtask

   task automatic t_halves;
      wr(ofs(1, 0), 32'h1111_1111);
      wr(ofs(1, 1), 32'h2222_2222);
      wr(ofs(1, 0), 32'h3333_3333);
      chk_rd("R3", ofs(1, 1), 32'h2222_2222);
      chk_rd("R3", ofs(1, 0), 32'h3333_3333);
      wr(ofs(1, 3), 32'h4444_4444);
      wr(ofs(1, 4), 32'h5555_5555);
      chk_rd("R3", ofs(1, 3), 32'h4444_4444);
   endtask

   task automatic t_bounds;
      wr(ofs(1, 2), 32'h0);
      prog(0, 64'h2_0000_0000, 64'h8000_0000, 32'hFFFF_F001);
      chk_lk("R5", 64'h2_0000_0000, 1'b1, 2'd0, 64'h8000_0000);
      chk_lk("R5", 64'h2_0000_0FFF, 1'b1, 2'd0, 64'h8000_0FFF);
      chk_lk("R5", 64'h2_0000_1000, 1'b0, 2'd0, 64'h0);
      chk_lk("R9", 64'h1_FFFF_FFFF, 1'b0, 2'd0, 64'h0);
      wr(ofs(0, 2), 32'hFFFF_F000);
      chk_lk("R4", 64'h2_0000_0000, 1'b0, 2'd0, 64'h0);
      chk_rd("R4", ofs(0, 2), 32'hFFFF_F000);
   endtask

   task automatic t_fullsize;
      wr(ofs(0, 2), 32'h0);
      prog(1, 64'h1_0000_0000, 64'hAB_0000_0000, 32'h0000_0001);
      chk_lk("R6", 64'h1_FFFF_FFFE, 1'b1, 2'd1, 64'hAB_FFFF_FFFE);
      chk_lk("R6", 64'h1_FFFF_FFFF, 1'b0, 2'd0, 64'h0);
   endtask

   task automatic t_translate;
      prog(1, 64'hFFFF_FFFF_F000_0000, 64'h12_3400_0000, 32'hF000_0001);
      chk_lk("R7", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd1, 64'h12_43FF_FFFF);
      chk_lk("R7", 64'hFFFF_FFFF_F123_4568, 1'b1, 2'd1, 64'h12_3523_4568);
      chk_lk("R7", 64'hFFFF_FFFF_EFFF_FFFF, 1'b0, 2'd0, 64'h0);
   endtask

   task automatic t_priority;
      prog(0, 64'h4000_0000, 64'h1000_0000, 32'hFFFF_0001);
      prog(1, 64'h4000_0000, 64'h2000_0000, 32'hFFFF_0001);
      chk_lk("R8", 64'h4000_0010, 1'b1, 2'd0, 64'h1000_0010);
      wr(ofs(0, 2), 32'hFFFF_0000);
      chk_lk("R8", 64'h4000_0010, 1'b1, 2'd1, 64'h2000_0010);
      wr(ofs(0, 2), 32'hFFFF_F001);
      chk_lk("R8", 64'h4000_0FF0, 1'b1, 2'd0, 64'h1000_0FF0);
      chk_lk("R8", 64'h4000_2000, 1'b1, 2'd1, 64'h2000_2000);
   endtask

   task automatic t_win2;
      wr(ofs(0, 2), 32'h0);
      wr(ofs(1, 2), 32'h0);
      wr(8'h90, 32'hFFFF_F001);
      chk_rd("R10", 8'h90, 32'hFFFF_F001);
      chk_lk("R10", 64'h10, 1'b0, 2'd0, 64'h0);
      chk_lk("R10", 64'h0, 1'b0, 2'd0, 64'h0);
   endtask

   task automatic t_unmapped;
      wr(8'h94, 32'hDEAD_BEEF);
      chk_rd("R11", 8'h94, 32'h0);
      wr(8'h6A, 32'hCAFE_F00D);
      chk_rd("R11", 8'h6A, 32'h0);
      chk_rd("R11", 8'h68, 32'h4000_0000);
      chk_rd("R11", 8'h90, 32'hFFFF_F001);
      chk_rd("R11", 8'h00, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_halves();
      t_bounds();
      t_fullsize();
      t_translate();
      t_priority();
      t_win2();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule